// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Two-Entry Queue

This block recovers asynchronous serial characters from a single idle-high line. A tick strobe at sixteen times the bit rate paces all timing. A falling edge on the line starts a character. The start bit is confirmed at its centre, and then every later bit is judged by a two-of-three vote near its centre. Each character has 8 data bits, or 9 when the wide mode is selected, and is closed by one stop bit.

Finished characters go into a small queue together with their ninth bit and a framing-error mark. The queue holds two characters while a third is still being shifted in. A consumer reads the queue head through a one-cycle read strobe. A level flag tells the consumer that unread data is waiting.

If a character completes while the queue has no room, the receiver drops that character and raises a sticky overrun flag. It then stops receiving until software clears the flag. Baud generation is not part of this block; the tick strobe comes from outside.

Top module: `uart_rx_os16`

## Requirements
- R1: Reception proceeds only while `rx_en` and `port_en` are both 1. While either is 0 the bit engine stays idle and characters on the line are not stored.
- R2: A tick that sees the line 0 after a tick that saw it 1 starts a character; this edge tick counts as tick 0. The start bit is voted at ticks 7, 8 and 9. If the majority is 1, the attempt is abandoned without any character or error, and edge search resumes.
- R3: Data bits arrive least significant first. Each bit is the 2-of-3 majority of the line at ticks 7, 8 and 9 of its 16-tick period, measured from the edge tick. A single disturbed sample does not change the bit.
- R4: When `nine_bit` is 1 at the edge tick, 9 data bits are collected and the ninth appears on `rd_bit9`. In 8-bit mode `rd_bit9` is 0.
- R5: The stop bit is voted like a data bit. A 0 result stores `rd_ferr`=1 with that character, and a 1 result stores 0. The mark travels with its own character through the queue.
- R6: The queue holds FIFO_DEPTH (default 2) characters in arrival order. `rd_stb` removes the head when the queue is not empty and is ignored when it is empty. `rd_data`, `rd_bit9` and `rd_ferr` show the head, or all zero when the queue is empty.
- R7: `data_avail` is 1 exactly when both enables are 1 and at least one character is queued. Queued characters survive a disable.
- R8: A character that completes with no room (after any pop in the same cycle) is discarded and sets `overrun`. The queue contents are kept, and no character is accepted while `overrun` is 1.
- R9: `ovr_clr`=1 or `rx_en`=0 clears `overrun` on the next edge and returns the bit engine to edge search.
- R10: A read of a full queue in the same cycle as a completing character frees the slot: the new character is stored and `overrun` stays 0.
- R11: The line passes through a two-flop synchronizer. After synchronous reset the line is taken as idle high, the queue is empty and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle strobe at 16x bit rate |
| rx_en | input | 1 | Receiver enable |
| port_en | input | 1 | Serial port enable |
| nine_bit | input | 1 | 1 selects 9 data bits per character |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rd_stb | input | 1 | Pops the queue head |
| ovr_clr | input | 1 | Clears the overrun condition |
| rd_data | output | 8 | Head character data bits |
| rd_bit9 | output | 1 | Head character ninth bit |
| rd_ferr | output | 1 | Head character framing-error mark |
| data_avail | output | 1 | Unread character present while enabled |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Two events can fall on the same clock edge. One is a character completing into a full queue; the other is a consumer read that frees a slot. The bench fills the queue and sends a third character. Its own timing model predicts the cycle in which that character lands, and the bench pulses `rd_stb` in exactly that cycle. The result is judged by `overrun` staying 0 and by the following reads returning the second and then the third character. A separate run omits the read, and there `overrun` must rise while the first two characters stay intact.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DW = 8;

  typedef enum logic [1:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP
  } rxq_state_e;

  typedef struct packed {
    logic              ferr;
    logic              bit9;
    logic [RXQ_DW-1:0] data;
  } rxq_word_t;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxq_bitrx.sv
module rxq_bitrx
  import rxq_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int VOTE_TICK = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      hold,
  input  logic      line,
  input  logic      nine_sel,
  output logic      push_o,
  output rxq_word_t word_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] T_A = CW'(VOTE_TICK - 1);
  localparam logic [CW-1:0] T_B = CW'(VOTE_TICK);
  localparam logic [CW-1:0] T_C = CW'(VOTE_TICK + 1);
  localparam int SW = RXQ_DW + 1;

  rxq_state_e    state;
  logic [CW-1:0] cnt;
  logic          last;
  logic          va, vb;
  logic [3:0]    bidx;
  logic          nine_q;
  logic [SW-1:0] shreg;
  logic          maj;
  logic [3:0]    last_idx;

  assign maj      = (va & vb) | (va & line) | (vb & line);
  assign last_idx = nine_q ? 4'(RXQ_DW) : 4'(RXQ_DW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      last   <= 1'b1;
      va     <= 1'b0;
      vb     <= 1'b0;
      bidx   <= '0;
      nine_q <= 1'b0;
      shreg  <= '0;
      push_o <= 1'b0;
      word_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick) last <= line;
      if (hold) begin
        state <= S_IDLE;
      end else if (tick) begin
        if (state == S_IDLE) begin
          if (last && !line) begin
            state  <= S_START;
            cnt    <= CW'(1);
            nine_q <= nine_sel;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == T_A) va <= line;
          if (cnt == T_B) vb <= line;
          if (cnt == T_C) begin
            case (state)
              S_START: begin
                if (maj) state <= S_IDLE;
                else begin
                  state <= S_DATA;
                  bidx  <= '0;
                end
              end
              S_DATA: begin
                shreg <= {maj, shreg[SW-1:1]};
                bidx  <= bidx + 1'b1;
                if (bidx == last_idx) state <= S_STOP;
              end
              S_STOP: begin
                push_o      <= 1'b1;
                word_o.data <= nine_q ? shreg[RXQ_DW-1:0] : shreg[RXQ_DW:1];
                word_o.bit9 <= nine_q & shreg[RXQ_DW];
                word_o.ferr <= ~maj;
                state       <= S_IDLE;
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [LW-1:0] cnt, after;
  logic          pop, accept;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop    = rd && (cnt != '0);
  assign after  = cnt - LW'(pop);
  assign accept = wr && (after < LW'(DEPTH));
  assign ovf    = wr && !accept;

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (pop)    rp <= step(rp);
      if (accept) wp <= step(wp);
      cnt <= after + LW'(accept);
    end
  end

  assign rdata = (cnt != '0) ? mem[rp] : '0;
  assign level = cnt;
endmodule

// File: rtl/uart_rx_os16.sv
module uart_rx_os16
  import rxq_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int VOTE_TICK   = 8,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rx_en,
  input  logic              port_en,
  input  logic              nine_bit,
  input  logic              rx_in,
  input  logic              rd_stb,
  input  logic              ovr_clr,
  output logic [RXQ_DW-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rd_ferr,
  output logic              data_avail,
  output logic              overrun
);
  localparam int WW = $bits(rxq_word_t);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic          line_s;
  logic          active, hold;
  logic          bit_push;
  rxq_word_t     bit_word;
  rxq_word_t     head;
  logic [LW-1:0] fifo_level;
  logic          fifo_ovf;
  logic          ovr_q;

  assign active = rx_en & port_en;
  assign hold   = ~active | ovr_q | ovr_clr;

  rxq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_in),
    .q   (line_s)
  );

  rxq_bitrx #(.OSR(OSR), .VOTE_TICK(VOTE_TICK)) u_bitrx (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick16),
    .hold     (hold),
    .line     (line_s),
    .nine_sel (nine_bit),
    .push_o   (bit_push),
    .word_o   (bit_word)
  );

  rxq_fifo #(.DEPTH(FIFO_DEPTH), .W(WW)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .wr    (bit_push),
    .wdata (bit_word),
    .rd    (rd_stb),
    .rdata (head),
    .level (fifo_level),
    .ovf   (fifo_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst)                    ovr_q <= 1'b0;
    else if (ovr_clr || !rx_en) ovr_q <= 1'b0;
    else if (fifo_ovf)          ovr_q <= 1'b1;
  end

  assign rd_data    = head.data;
  assign rd_bit9    = head.bit9;
  assign rd_ferr    = head.ferr;
  assign data_avail = active & (fifo_level != '0);
  assign overrun    = ovr_q;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rd_stb,
  input logic                       ovr_clr,
  input logic                       rx_en,
  input logic                       overrun,
  input logic                       push,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       data_avail
);
  localparam int LW = $clog2(DEPTH + 1);

  p_level_bound_r6: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  p_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && level != '0 && !push) |=> (level == $past(level) - 1'b1));

  p_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !data_avail);

  p_full_push_r8: assert property (@(posedge clk) disable iff (rst)
    (push && level == LW'(DEPTH) && !rd_stb && !ovr_clr && rx_en) |=> overrun);

  p_locked_r8: assert property (@(posedge clk) disable iff (rst)
    overrun |-> !push);

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr && rx_en) |=> overrun);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (ovr_clr || !rx_en) |=> !overrun);

  p_coincide_r10: assert property (@(posedge clk) disable iff (rst)
    (push && rd_stb && level == LW'(DEPTH)) |=> (level == LW'(DEPTH) && !overrun));
endmodule

bind uart_rx_os16 rxq_chk #(.DEPTH(FIFO_DEPTH)) u_rxq_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_stb     (rd_stb),
  .ovr_clr    (ovr_clr),
  .rx_en      (rx_en),
  .overrun    (overrun),
  .push       (bit_push),
  .level      (fifo_level),
  .data_avail (data_avail)
);

// File: tb/uart_rx_os16_bench.sv
module uart_rx_os16_bench;
  localparam int DEPTH = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_en = 1'b1, port_en = 1'b1, nine_bit = 1'b0;
  logic       rx_in = 1'b1, rd_stb = 1'b0, ovr_clr = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit9, rd_ferr, data_avail, overrun;

  int checks = 0;
  int errors = 0;
  int tc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_os16 u_uart_rx_os16 (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_en(rx_en), .port_en(port_en),
    .nine_bit(nine_bit), .rx_in(rx_in), .rd_stb(rd_stb), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr),
    .data_avail(data_avail), .overrun(overrun)
  );

  always @(negedge clk) begin
    tc = (tc + 1) % 4;
    tick16 = (tc == 0);
  end

  // Behavioural reference: line seen two clocks late, tick-counted frame, queue.
  logic       m_s1, m_s2, m_last, m_v7, m_v8, m_nine, m_pend, m_ovr;
  logic       m_line, m_act, m_ovf, m_newp, m_hold, m_maj;
  logic [8:0] m_word;
  logic [9:0] m_pw;
  logic [9:0] q[$];
  int         m_st, m_k, m_bit, m_pos;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_last = 1; m_st = 0; m_pend = 0; m_ovr = 0;
      m_k = 0; m_bit = 0; m_word = 0; m_pw = 0; m_nine = 0; m_v7 = 0; m_v8 = 0;
      q.delete();
    end else begin
      m_line = m_s2;
      m_act  = rx_en & port_en;
      if (rd_stb && q.size() > 0) void'(q.pop_front());
      m_ovf = 0;
      if (m_pend) begin
        if (q.size() < DEPTH) q.push_back(m_pw);
        else m_ovf = 1;
      end
      m_hold = !m_act || m_ovr || ovr_clr;
      if (ovr_clr || !rx_en) m_ovr = 0;
      else if (m_ovf) m_ovr = 1;
      m_newp = 0;
      if (m_hold) m_st = 0;
      else if (tick16) begin
        if (m_st == 0) begin
          if (m_last && !m_line) begin
            m_st = 1; m_k = 0; m_nine = nine_bit; m_bit = 0; m_word = 0;
          end
        end else begin
          m_k++;
          m_pos = m_k % 16;
          if (m_pos == 7) m_v7 = m_line;
          if (m_pos == 8) m_v8 = m_line;
          if (m_pos == 9) begin
            m_maj = (int'(m_v7) + int'(m_v8) + int'(m_line)) >= 2;
            if (m_st == 1) m_st = m_maj ? 0 : 2;
            else if (m_st == 2) begin
              m_word[m_bit] = m_maj;
              m_bit++;
              if (m_bit == (m_nine ? 9 : 8)) m_st = 3;
            end else begin
              m_newp = 1;
              m_pw = {~m_maj, m_word[8], m_word[7:0]};
              m_st = 0;
            end
          end
        end
      end
      if (tick16) m_last = m_line;
      m_s2 = m_s1;
      m_s1 = rx_in;
      m_pend = m_newp;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // Per-clock comparison against the reference model.
  always begin
    @(negedge clk);
    #1;
    if (!rst) begin
      logic [9:0] h;
      h = (q.size() > 0) ? q[0] : 10'h0;
      chk("R7 data_avail model", 16'(data_avail), 16'((rx_en & port_en) && q.size() > 0));
      chk("R3 rd_data model", 16'(rd_data), 16'(h[7:0]));
      chk("R4 rd_bit9 model", 16'(rd_bit9), 16'(h[8]));
      chk("R5 rd_ferr model", 16'(rd_ferr), 16'(h[9]));
      chk("R8 overrun model", 16'(overrun), 16'(m_ovr));
    end
  end

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic one_tick();
    @(posedge clk);
    while (!tick16) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int gt);
    for (int i = 0; i < 16; i++) begin
      rx_in = (i == gt) ? ~b : b;
      one_tick();
    end
  endtask

  task automatic send_frame(input logic [8:0] val, input int nb, input logic stopv,
                            input int gbit, input int gtick);
    one_tick();
    send_bit(1'b0, (gbit == 0) ? gtick : -1);
    for (int i = 0; i < nb; i++) send_bit(val[i], (gbit == i + 1) ? gtick : -1);
    send_bit(stopv, (gbit == nb + 1) ? gtick : -1);
    rx_in = 1'b1;
    for (int i = 0; i < 3; i++) one_tick();
  endtask

  task automatic read_one();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    settle();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    settle();
    // R11 reset state
    chk("R11 avail after reset", 16'(data_avail), 16'h0);
    chk("R11 overrun after reset", 16'(overrun), 16'h0);
    chk("R11 data after reset", 16'(rd_data), 16'h0);

    // R3 basic character
    send_frame(9'h0A5, 8, 1'b1, -1, 0);
    settle();
    chk("R3 data A5", 16'(rd_data), 16'hA5);
    chk("R7 avail set", 16'(data_avail), 16'h1);
    chk("R4 bit9 zero in 8-bit", 16'(rd_bit9), 16'h0);
    read_one();
    chk("R6 empty after read", 16'(data_avail), 16'h0);
    chk("R6 zero head when empty", 16'(rd_data), 16'h0);

    // R3 single disturbed vote sample, in start and in a data bit
    send_frame(9'h03C, 8, 1'b1, 3, 8);
    send_frame(9'h0C3, 8, 1'b1, 0, 7);
    settle();
    chk("R3 glitch ignored", 16'(rd_data), 16'h3C);
    read_one();
    chk("R3 glitch in start ignored", 16'(rd_data), 16'hC3);
    read_one();

    // R2 false start
    one_tick();
    rx_in = 1'b0;
    for (int i = 0; i < 5; i++) one_tick();
    rx_in = 1'b1;
    for (int i = 0; i < 20; i++) one_tick();
    settle();
    chk("R2 false start no char", 16'(data_avail), 16'h0);
    chk("R2 false start no overrun", 16'(overrun), 16'h0);
    send_frame(9'h05A, 8, 1'b1, -1, 0);
    settle();
    chk("R2 next char ok", 16'(rd_data), 16'h5A);
    read_one();

    // R4 nine-bit mode
    nine_bit = 1'b1;
    send_frame(9'h1C3, 9, 1'b1, -1, 0);
    send_frame(9'h0F0, 9, 1'b1, -1, 0);
    nine_bit = 1'b0;
    settle();
    chk("R4 nine data", 16'(rd_data), 16'hC3);
    chk("R4 ninth bit one", 16'(rd_bit9), 16'h1);
    read_one();
    chk("R4 ninth bit zero", 16'(rd_bit9), 16'h0);
    chk("R4 second nine data", 16'(rd_data), 16'hF0);
    read_one();

    // R5 framing error stored per character
    send_frame(9'h081, 8, 1'b0, -1, 0);
    send_frame(9'h07E, 8, 1'b1, -1, 0);
    settle();
    chk("R5 ferr set", 16'(rd_ferr), 16'h1);
    chk("R5 data with ferr", 16'(rd_data), 16'h81);
    read_one();
    chk("R5 ferr clear next", 16'(rd_ferr), 16'h0);
    chk("R5 next data", 16'(rd_data), 16'h7E);
    read_one();

    // R1 port disabled, R6 read on empty ignored
    port_en = 1'b0;
    send_frame(9'h099, 8, 1'b1, -1, 0);
    port_en = 1'b1;
    settle();
    chk("R1 no char while disabled", 16'(data_avail), 16'h0);
    read_one();
    send_frame(9'h042, 8, 1'b1, -1, 0);
    settle();
    chk("R6 empty read ignored data", 16'(rd_data), 16'h42);
    chk("R6 empty read ignored avail", 16'(data_avail), 16'h1);
    read_one();
    chk("R6 single entry popped", 16'(data_avail), 16'h0);

    // R8 overrun and lockout, R9 clear
    send_frame(9'h011, 8, 1'b1, -1, 0);
    send_frame(9'h022, 8, 1'b1, -1, 0);
    send_frame(9'h033, 8, 1'b1, -1, 0);
    settle();
    chk("R8 overrun set", 16'(overrun), 16'h1);
    chk("R8 head kept", 16'(rd_data), 16'h11);
    send_frame(9'h044, 8, 1'b1, -1, 0);
    read_one();
    chk("R8 second kept", 16'(rd_data), 16'h22);
    read_one();
    chk("R8 locked out", 16'(data_avail), 16'h0);
    chk("R8 still overrun", 16'(overrun), 16'h1);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    settle();
    chk("R9 cleared", 16'(overrun), 16'h0);
    send_frame(9'h055, 8, 1'b1, -1, 0);
    settle();
    chk("R9 receives again", 16'(rd_data), 16'h55);
    read_one();

    // R7 avail gated by enable, R9 clear by rx_en
    send_frame(9'h066, 8, 1'b1, -1, 0);
    @(negedge clk);
    rx_en = 1'b0;
    settle();
    chk("R7 avail low when disabled", 16'(data_avail), 16'h0);
    @(negedge clk);
    rx_en = 1'b1;
    settle();
    chk("R7 avail back", 16'(data_avail), 16'h1);
    chk("R7 data kept", 16'(rd_data), 16'h66);
    send_frame(9'h077, 8, 1'b1, -1, 0);
    send_frame(9'h088, 8, 1'b1, -1, 0);
    settle();
    chk("R8 overrun again", 16'(overrun), 16'h1);
    @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    settle();
    chk("R9 rx_en clears overrun", 16'(overrun), 16'h0);
    read_one();
    read_one();
    chk("R6 drained", 16'(data_avail), 16'h0);

    // R10 read and completion in the same cycle
    send_frame(9'h0A1, 8, 1'b1, -1, 0);
    send_frame(9'h0B2, 8, 1'b1, -1, 0);
    fork
      send_frame(9'h0C3, 8, 1'b1, -1, 0);
      begin
        do @(negedge clk); while (!m_pend);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
      end
    join
    settle();
    chk("R10 no overrun", 16'(overrun), 16'h0);
    chk("R10 head second", 16'(rd_data), 16'hB2);
    read_one();
    chk("R10 third stored", 16'(rd_data), 16'hC3);
    read_one();
    chk("R10 drained", 16'(data_avail), 16'h0);

    done = 1;
    finish_run();
  end
endmodule